// File: doc/BRIEF.md
# Startup Sequencer with Configuration Strap Latch

This block brings a measurement datapath out of reset in a defined order. The measurement logic stays in reset while the supply-good indication is low or the external active-low reset is asserted. Both of these inputs are synchronized to the clock first. Once both are released, the block waits a short oscillator-settling delay. It then reads the board straps once and holds what it read on registered outputs for the rest of the datapath. The straps are a 2-bit current-gain code, a 3-bit pulse-rate code and a high-pass filter option pin.

The filter option pin has three meanings. Strapped high, it turns the filter off. Strapped low, it selects the filter on the voltage channel. Wired to the calibration pulse output, it selects the filter on the current channel. A level sample cannot detect the third case. During initialization the block therefore drives a fixed toggle pattern on the calibration output (`cal_probe`) and watches whether the option pin follows it.

When the settings are latched, a one-cycle strobe marks them valid. In the same cycle the measurement reset is released.

Top module: `startup_strap_latch`

## Requirements
- R1: While `supply_ok` or `ext_rst_n` is low, `meas_rst_n` is low. After either input falls, `meas_rst_n` and `cfg_valid` are low no later than the third rising clock edge (two synchronizer stages plus one sequencer register).
- R2: After both inputs are high, the block waits `SETTLE_CYC` (default 8) clock cycles and then probes for `PROBE_LEN` (default 4) cycles. `cfg_valid` goes high after the 16th rising edge counted from the release, with default parameters.
- R3: `cfg_valid` is high for exactly one cycle. It rises in the same cycle as `meas_rst_n`.
- R4: The straps are read only once per startup. Changes on `gain_pin`, `rate_pin` or `filt_pin` after `cfg_valid` leave `gain_sel`, `gain_mult`, `rate_sel` and `filt_mode` unchanged until the next reset.
- R5: `gain_sel` holds the sampled gain code. `gain_mult` decodes it as 00→10, 01→50, 10→100, 11→150.
- R6: A filter pin that is not tied to the probe is classed by its level in the latch cycle. High gives `filt_mode` 0 (off) and low gives `filt_mode` 1 (voltage channel). `filt_mode` 3 is never produced.
- R7: During the probe window, `cal_probe` drives the pattern 0,1,1,0 (`PROBE_PAT` LSB first, one bit per cycle). Outside that window it is low. A pin that matches `cal_probe` on every probe cycle gives `filt_mode` 2 (current channel).
- R8: A pin that misses any probe level is not classed as tied, even if it toggles. For example, a pin driven with the inverse of the probe reads high in the latch cycle and gives `filt_mode` 0.
- R9: A reset applied during the settle or probe phase restarts the whole sequence. The full latency of R2 then counts again from the new release.
- R10: While in reset, all of the following are zero: `gain_sel`, `gain_mult`, `rate_sel`, `filt_mode`, `cfg_valid` and `cal_probe`.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | Block clock |
| ext_rst_n | input | 1 | External reset, active low, asynchronous to clk |
| supply_ok | input | 1 | Supply-good indication, asynchronous to clk |
| gain_pin | input | 2 | Current-gain strap |
| rate_pin | input | 3 | Pulse-rate strap |
| filt_pin | input | 1 | High-pass filter option strap |
| cal_probe | output | 1 | Probe pattern driven onto the calibration output during initialization |
| meas_rst_n | output | 1 | Reset to the measurement logic, active low |
| cfg_valid | output | 1 | One-cycle strobe when the settings are latched |
| gain_sel | output | 2 | Latched gain code |
| gain_mult | output | 8 | Decoded gain factor |
| rate_sel | output | 3 | Latched pulse-rate code |
| filt_mode | output | 2 | 0 off, 1 voltage channel, 2 current channel |

## Verification
The hardest case to reach from the ports is a filter pin that moves but does not truly follow the probe. A pin strapped to the inverse of `cal_probe` is used for this, because it toggles through the whole probe window. The bench builds this by wiring `filt_pin` combinationally from `cal_probe` in one of four strap modes: low, high, tied and inverted. A restart in the middle of the settle phase is brought about by pulsing the external reset a few cycles after release. The bench then requires the full startup latency from the second release.

// File: rtl/strap_boot_pkg.sv
// Shared types and decode helpers for the startup strap latch.
// Assumes the gain strap is a 2-bit code with four fixed factors.
package strap_boot_pkg;

    typedef enum logic [2:0] {
        ST_HOLD   = 3'd0,
        ST_SETTLE = 3'd1,
        ST_PROBE  = 3'd2,
        ST_LATCH  = 3'd3,
        ST_RUN    = 3'd4
    } boot_state_t;

    typedef enum logic [1:0] {
        FILT_OFF  = 2'd0,
        FILT_VOLT = 2'd1,
        FILT_CURR = 2'd2
    } filt_mode_t;

    // Maps the 2-bit gain strap to its amplification factor.
    function automatic logic [7:0] gain_factor(input logic [1:0] code);
        case (code)
            2'b00:   return 8'd10;
            2'b01:   return 8'd50;
            2'b10:   return 8'd100;
            default: return 8'd150;
        endcase
    endfunction

endpackage

// File: rtl/boot_sync.sv
// Multi-stage synchronizer for a single asynchronous level.
// It has no reset: the level is expected to stay stable for longer than STAGES cycles.
module boot_sync #(
    parameter int STAGES = 2
) (
    input  logic clk,
    input  logic d,
    output logic q
);
    logic [STAGES-1:0] chain;

    generate
        if (STAGES == 1) begin : g_one
            // Single capture stage.
            always_ff @(posedge clk) chain <= d;
        end else begin : g_many
            // Shift the level through the stage chain.
            always_ff @(posedge clk) chain <= {chain[STAGES-2:0], d};
        end
    endgenerate

    assign q = chain[STAGES-1];
endmodule

// File: rtl/boot_sequencer.sv
// Startup state machine: hold, settle for SETTLE_CYC cycles, probe for
// PROBE_LEN cycles, one latch cycle, then run until run_n drops.
// Assumes run is already synchronous to clk; !run acts as synchronous reset.
module boot_sequencer
    import strap_boot_pkg::*;
#(
    parameter int SETTLE_CYC = 8,
    parameter int PROBE_LEN  = 4,
    localparam int SCW = $clog2(SETTLE_CYC + 1),
    localparam int IW  = (PROBE_LEN > 1) ? $clog2(PROBE_LEN) : 1
) (
    input  logic          clk,
    input  logic          run,
    output boot_state_t   state,
    output logic [IW-1:0] probe_idx
);
    logic [SCW-1:0] settle_cnt;

    // Advance the startup phases; any loss of run returns to hold.
    always_ff @(posedge clk) begin
        if (!run) begin
            state      <= ST_HOLD;
            settle_cnt <= '0;
            probe_idx  <= '0;
        end else begin
            case (state)
                ST_HOLD: begin
                    state      <= ST_SETTLE;
                    settle_cnt <= '0;
                end
                ST_SETTLE: begin
                    if (settle_cnt == SCW'(SETTLE_CYC - 1)) begin
                        state     <= ST_PROBE;
                        probe_idx <= '0;
                    end else begin
                        settle_cnt <= settle_cnt + 1'b1;
                    end
                end
                ST_PROBE: begin
                    if (probe_idx == IW'(PROBE_LEN - 1)) state <= ST_LATCH;
                    else                                 probe_idx <= probe_idx + 1'b1;
                end
                ST_LATCH: state <= ST_RUN;
                default:  state <= ST_RUN;
            endcase
        end
    end
endmodule

// File: rtl/boot_strap_probe.sv
// Drives the probe pattern on the calibration output during the probe phase
// and records whether the filter strap followed every level of it.
// Assumes the strap is a static board connection, so it needs no synchronizer.
module boot_strap_probe
    import strap_boot_pkg::*;
#(
    parameter int                   PROBE_LEN = 4,
    parameter logic [PROBE_LEN-1:0] PROBE_PAT = 4'b0110,
    localparam int IW = (PROBE_LEN > 1) ? $clog2(PROBE_LEN) : 1
) (
    input  logic          clk,
    input  logic          run,
    input  boot_state_t   state,
    input  logic [IW-1:0] probe_idx,
    input  logic          strap_in,
    output logic          probe_out,
    output logic          tied
);
    logic missed;

    // Pattern bit for the current probe cycle; idle low elsewhere.
    always_comb probe_out = (state == ST_PROBE) ? PROBE_PAT[probe_idx] : 1'b0;

    // Remember any probe cycle on which the strap differed from the probe.
    always_ff @(posedge clk) begin
        if (!run || state == ST_SETTLE) missed <= 1'b0;
        else if (state == ST_PROBE && strap_in != probe_out) missed <= 1'b1;
    end

    assign tied = !missed;
endmodule

// File: rtl/startup_strap_latch.sv
// Top of the startup sequencer. It synchronizes reset and supply-good,
// sequences settle/probe/latch, and holds the strap settings in registers.
// Assumes the straps are static while the block is running.
module startup_strap_latch
    import strap_boot_pkg::*;
#(
    parameter int                   SYNC_STAGES = 2,
    parameter int                   SETTLE_CYC  = 8,
    parameter int                   PROBE_LEN   = 4,
    parameter logic [PROBE_LEN-1:0] PROBE_PAT   = 4'b0110,
    localparam int IW = (PROBE_LEN > 1) ? $clog2(PROBE_LEN) : 1
) (
    input  logic       clk,
    input  logic       ext_rst_n,
    input  logic       supply_ok,
    input  logic [1:0] gain_pin,
    input  logic [2:0] rate_pin,
    input  logic       filt_pin,
    output logic       cal_probe,
    output logic       meas_rst_n,
    output logic       cfg_valid,
    output logic [1:0] gain_sel,
    output logic [7:0] gain_mult,
    output logic [2:0] rate_sel,
    output logic [1:0] filt_mode
);
    logic          rst_s;
    logic          supply_s;
    logic          run_s;
    boot_state_t   state;
    logic [IW-1:0] probe_idx;
    logic          tied;

    boot_sync #(.STAGES(SYNC_STAGES)) u_sync_rst (
        .clk (clk), .d (ext_rst_n), .q (rst_s)
    );
    boot_sync #(.STAGES(SYNC_STAGES)) u_sync_sup (
        .clk (clk), .d (supply_ok), .q (supply_s)
    );

    assign run_s = rst_s & supply_s;

    boot_sequencer #(.SETTLE_CYC(SETTLE_CYC), .PROBE_LEN(PROBE_LEN)) u_seq (
        .clk (clk), .run (run_s), .state (state), .probe_idx (probe_idx)
    );

    boot_strap_probe #(.PROBE_LEN(PROBE_LEN), .PROBE_PAT(PROBE_PAT)) u_probe (
        .clk       (clk),
        .run       (run_s),
        .state     (state),
        .probe_idx (probe_idx),
        .strap_in  (filt_pin),
        .probe_out (cal_probe),
        .tied      (tied)
    );

    // Capture the straps once in the latch cycle and release the datapath.
    always_ff @(posedge clk) begin
        if (!run_s) begin
            meas_rst_n <= 1'b0;
            cfg_valid  <= 1'b0;
            gain_sel   <= '0;
            gain_mult  <= '0;
            rate_sel   <= '0;
            filt_mode  <= FILT_OFF;
        end else if (state == ST_LATCH) begin
            meas_rst_n <= 1'b1;
            cfg_valid  <= 1'b1;
            gain_sel   <= gain_pin;
            gain_mult  <= gain_factor(gain_pin);
            rate_sel   <= rate_pin;
            if (tied)          filt_mode <= FILT_CURR;
            else if (filt_pin) filt_mode <= FILT_OFF;
            else               filt_mode <= FILT_VOLT;
        end else begin
            cfg_valid  <= 1'b0;
        end
    end
endmodule

// File: rtl/startup_strap_latch_checker.sv
// Property checker for the startup strap latch; bound to the top module.
module startup_strap_latch_checker
    import strap_boot_pkg::*;
#(
    parameter int SETTLE_CYC = 8,
    parameter int PROBE_LEN  = 4,
    localparam int CW = $clog2(SETTLE_CYC + PROBE_LEN + 4) + 1
) (
    input logic       clk,
    input logic       ext_rst_n,
    input logic       supply_s,
    input logic       run_s,
    input logic       cal_probe,
    input logic       meas_rst_n,
    input logic       cfg_valid,
    input logic [1:0] gain_sel,
    input logic [7:0] gain_mult,
    input logic [2:0] rate_sel,
    input logic [1:0] filt_mode
);
    logic [CW-1:0] up_cnt;

    // Count cycles since the synchronized run level rose, saturating.
    always_ff @(posedge clk) begin
        if (!run_s) up_cnt <= '0;
        else if (up_cnt != '1) up_cnt <= up_cnt + 1'b1;
    end

    assert_supply_hold_R1: assert property (@(posedge clk) disable iff (!ext_rst_n)
        !supply_s |=> (!meas_rst_n && !cfg_valid));

    assert_latency_R2: assert property (@(posedge clk) disable iff (!ext_rst_n)
        cfg_valid |-> (up_cnt == CW'(SETTLE_CYC + PROBE_LEN + 2)));

    assert_one_shot_R3: assert property (@(posedge clk) disable iff (!ext_rst_n)
        cfg_valid |=> !cfg_valid);

    assert_with_release_R3: assert property (@(posedge clk) disable iff (!ext_rst_n)
        cfg_valid |-> (meas_rst_n && !$past(meas_rst_n)));

    assert_stable_cfg_R4: assert property (@(posedge clk) disable iff (!ext_rst_n)
        (meas_rst_n && $past(meas_rst_n)) |->
        ($stable(gain_sel) && $stable(rate_sel) && $stable(filt_mode) && $stable(gain_mult)));

    assert_gain_decode_R5: assert property (@(posedge clk) disable iff (!ext_rst_n)
        meas_rst_n |-> (gain_mult == gain_factor(gain_sel)));

    assert_mode_legal_R6: assert property (@(posedge clk) disable iff (!ext_rst_n)
        filt_mode != 2'd3);

    assert_probe_idle_R7: assert property (@(posedge clk) disable iff (!ext_rst_n)
        meas_rst_n |-> !cal_probe);
endmodule

bind startup_strap_latch startup_strap_latch_checker #(
    .SETTLE_CYC (SETTLE_CYC),
    .PROBE_LEN  (PROBE_LEN)
) u_chk (
    .clk        (clk),
    .ext_rst_n  (ext_rst_n),
    .supply_s   (supply_s),
    .run_s      (run_s),
    .cal_probe  (cal_probe),
    .meas_rst_n (meas_rst_n),
    .cfg_valid  (cfg_valid),
    .gain_sel   (gain_sel),
    .gain_mult  (gain_mult),
    .rate_sel   (rate_sel),
    .filt_mode  (filt_mode)
);

// File: tb/startup_strap_latch_test.sv
// Scoreboard bench: the driver pushes the expected latched settings and the
// monitor compares them when cfg_valid appears, along with the startup latency.
module startup_strap_latch_test;
    localparam int LATENCY = 2 + 1 + 8 + 4 + 1;
    localparam logic [3:0] PAT = 4'b0110;

    typedef struct {
        logic [1:0] gain;
        logic [7:0] mult;
        logic [2:0] rate;
        logic [1:0] mode;
    } exp_t;

    logic clk = 1'b0;
    logic ext_rst_n = 1'b0;
    logic supply_ok = 1'b0;
    logic [1:0] gain_pin = '0;
    logic [2:0] rate_pin = '0;
    logic [1:0] strap_kind = 2'd0;   // 0 low, 1 high, 2 tied, 3 inverted
    logic filt_pin;
    logic cal_probe, meas_rst_n, cfg_valid;
    logic [1:0] gain_sel, filt_mode;
    logic [7:0] gain_mult;
    logic [2:0] rate_sel;

    int checks = 0;
    int errors = 0;
    int rel_cyc = 0;
    bit counting = 1'b0;
    bit done = 1'b0;
    exp_t sb[$];

    always #5 clk = ~clk;

    assign filt_pin = (strap_kind == 2'd2) ? cal_probe :
                      (strap_kind == 2'd3) ? ~cal_probe : (strap_kind == 2'd1);

    startup_strap_latch uut (
        .clk (clk), .ext_rst_n (ext_rst_n), .supply_ok (supply_ok),
        .gain_pin (gain_pin), .rate_pin (rate_pin), .filt_pin (filt_pin),
        .cal_probe (cal_probe), .meas_rst_n (meas_rst_n), .cfg_valid (cfg_valid),
        .gain_sel (gain_sel), .gain_mult (gain_mult), .rate_sel (rate_sel),
        .filt_mode (filt_mode)
    );

    task automatic check(input bit ok, input string req, input string what,
                         input int act, input int exp);
        checks++;
        if (!ok) begin
            errors++;
            $display("FAIL %s %s actual=%0d expected=%0d", req, what, act, exp);
        end
    endtask

    function automatic logic [7:0] mult_of(input logic [1:0] g);
        return (g == 2'd0) ? 8'd10 : (g == 2'd1) ? 8'd50 : (g == 2'd2) ? 8'd100 : 8'd150;
    endfunction

    // Rising edges since the last release.
    always @(posedge clk) if (counting) rel_cyc++;

    // Monitor: probe pattern timing, and scoreboard compare on the strobe.
    always @(negedge clk) begin
        if (counting && rel_cyc >= 1 && rel_cyc <= LATENCY) begin
            logic e;
            e = (rel_cyc >= 11 && rel_cyc <= 14) ? PAT[rel_cyc - 11] : 1'b0;
            check(cal_probe == e, "R7", "cal_probe pattern", cal_probe, e);
        end
        if (cfg_valid) begin
            if (sb.size() == 0) begin
                check(1'b0, "R3", "unexpected cfg_valid", 1, 0);
            end else begin
                exp_t x;
                x = sb.pop_front();
                check(rel_cyc == LATENCY, "R2", "startup latency", rel_cyc, LATENCY);
                check(meas_rst_n == 1'b1, "R3", "meas_rst_n with strobe", meas_rst_n, 1);
                check(gain_sel == x.gain, "R5", "gain_sel", gain_sel, x.gain);
                check(gain_mult == x.mult, "R5", "gain_mult", gain_mult, x.mult);
                check(rate_sel == x.rate, "R4", "rate_sel", rate_sel, x.rate);
                check(filt_mode == x.mode, "R6_R7_R8", "filt_mode", filt_mode, x.mode);
            end
        end
    end

    // Driver: set straps, push expectation, release via the chosen input.
    task automatic boot(input logic [1:0] g, input logic [2:0] r,
                        input logic [1:0] kind, input bit via_supply);
        exp_t x;
        @(negedge clk);
        ext_rst_n = via_supply;
        supply_ok = !via_supply;
        repeat (4) @(negedge clk);
        gain_pin = g; rate_pin = r; strap_kind = kind;
        x.gain = g; x.mult = mult_of(g); x.rate = r;
        x.mode = (kind == 2'd2) ? 2'd2 : (kind == 2'd0) ? 2'd1 : 2'd0;
        sb.push_back(x);
        ext_rst_n = 1'b1; supply_ok = 1'b1;
        rel_cyc = 0; counting = 1'b1;
    endtask

    task automatic wait_done();
        for (int i = 0; i < 40 && sb.size() != 0; i++) @(negedge clk);
        check(sb.size() == 0, "R2", "cfg_valid seen", sb.size(), 0);
        repeat (2) @(negedge clk);
        check(cfg_valid == 1'b0, "R3", "strobe cleared", cfg_valid, 0);
    endtask

    task automatic check_reset_state(input string req);
        check(meas_rst_n == 1'b0, req, "meas_rst_n in reset", meas_rst_n, 0);
        check(cfg_valid == 1'b0, "R10", "cfg_valid in reset", cfg_valid, 0);
        check(gain_mult == 8'd0 && gain_sel == 2'd0, "R10", "gain in reset", gain_mult, 0);
        check(rate_sel == 3'd0 && filt_mode == 2'd0, "R10", "rate/mode in reset", rate_sel, 0);
        check(cal_probe == 1'b0, "R10", "cal_probe in reset", cal_probe, 0);
    endtask

    initial begin
        repeat (6) @(negedge clk);
        check_reset_state("R1");

        // Low strap, release through the external reset.
        boot(2'b00, 3'b000, 2'd0, 1'b0);
        wait_done();
        // High strap, release through supply-good.
        boot(2'b01, 3'b011, 2'd1, 1'b1);
        wait_done();
        // Tied strap selects the current channel.
        boot(2'b10, 3'b101, 2'd2, 1'b0);
        wait_done();

        // R4: strap changes after latch are ignored.
        gain_pin = 2'b01; rate_pin = 3'b010; strap_kind = 2'd1;
        repeat (6) @(negedge clk);
        check(gain_sel == 2'b10 && gain_mult == 8'd100, "R4", "gain held", gain_sel, 2);
        check(rate_sel == 3'b101, "R4", "rate held", rate_sel, 5);
        check(filt_mode == 2'd2, "R4", "filt_mode held", filt_mode, 2);

        // R1: supply-good drop forces reset within three edges.
        supply_ok = 1'b0; counting = 1'b0;
        repeat (2) @(negedge clk);
        check(meas_rst_n == 1'b1, "R1", "release still held after two edges", meas_rst_n, 1);
        @(negedge clk);
        check_reset_state("R1");
        supply_ok = 1'b1;

        // Inverted strap toggles but is not tied.
        boot(2'b11, 3'b111, 2'd3, 1'b0);
        wait_done();

        // R9: reset pulse during settle restarts the sequence.
        boot(2'b11, 3'b010, 2'd2, 1'b0);
        repeat (6) @(negedge clk);
        ext_rst_n = 1'b0;
        repeat (3) @(negedge clk);
        check(meas_rst_n == 1'b0, "R9", "no release after abort", meas_rst_n, 0);
        ext_rst_n = 1'b1;
        rel_cyc = 0;
        wait_done();

        done = 1'b1;
        $display("CHECKS %0d ERRORS %0d", checks, errors);
        $finish;
    end

    initial begin
        #(200000 * 10);
        if (!done) begin
            checks++; errors++;
            $display("FAIL watchdog actual=0 expected=1");
            $display("CHECKS %0d ERRORS %0d", checks, errors);
            $finish;
        end
    end
endmodule